// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

This block moves one outgoing Ethernet frame from memory to a MAC transmitter under the control of an in-memory descriptor. Software prepares a descriptor in a ring held in memory and sets its ownership bit. It then writes to a poll register. On that write the engine reads the descriptor at the current ring position. When hardware owns the descriptor, the engine reads the frame buffer word by word and offers it one byte at a time on a valid/ready stream. It marks the frame boundaries that the descriptor requests. It then writes a status word back over the first descriptor word, which also returns ownership to software.

Each descriptor occupies four 32-bit words. Word 0 carries the ownership flag and the returned status. Word 1 carries the byte count, the segment markers and an end-of-ring flag. Word 2 is the buffer's byte address. Word 3 is not read. After each completed descriptor the ring position moves forward by one descriptor, or goes back to the ring base when the end-of-ring flag was set. A one-cycle completion pulse follows every write-back and can feed an interrupt status bit.

Top module: `txdesc_engine`

## Requirements
- R1: After reset, `mem_req`, `tx_valid` and `tx_done` are low, both enable bits are clear and the ring base and ring position are zero.
- R2: A write of any data to register offset 0x18 is a poll. A poll taken while idle with both enables set starts a read of descriptor word 0 at the current ring position. The control register is at offset 0x00. The ring base register is at offset 0x20 and holds a byte address whose bits [1:0] are ignored. Writing the base also reloads the ring position.
- R3: A poll is ignored, and no memory request follows, unless control bit 0 (DMA enable) and control bit 5 (transmit enable) are both set.
- R4: If bit 31 of descriptor word 0 is clear, the engine returns to idle. It makes no further memory access, sends no byte, raises no `tx_done` and leaves the ring position unchanged.
- R5: For an owned descriptor, words 1 and 2 are read next at the two following word addresses. The byte count is word 1 bits [10:0]. Word 2 is the buffer byte address, which must be word aligned.
- R6: Exactly the byte count is sent. The engine reads consecutive buffer words and sends each word least significant byte first (bits [7:0] first). It reads only the words that hold frame bytes.
- R7: `tx_first` is high on the first byte only, and only if word 1 bit 28 is set. `tx_last` is high on the final byte only, and only if word 1 bit 27 is set.
- R8: While `tx_valid` is high and `tx_ready` is low, the byte and its markers stay unchanged. While `mem_req` is high and `mem_ready` is low, the address and the write flag stay unchanged.
- R9: After the final byte (or at once for a byte count of zero), the engine writes descriptor word 0. In that word bit 31 is clear, bit 0 is set if `mac_late_col` was high in any cycle a byte was offered, bit 1 is set likewise for `mac_exc_col`, and all other bits are zero.
- R10: `tx_done` is high for exactly one cycle: the cycle after the write-back is accepted.
- R11: After a write-back, the ring position moves forward by four words (16 bytes). If word 1 bit 31 was set, it returns to the ring base instead.
- R12: A poll that arrives while a descriptor is in progress is ignored and causes no extra fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | REG_AW | Register byte offset |
| reg_wr_data | input | 32 | Register write data |
| mem_req | output | 1 | Memory request, held until accepted |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid, at least one cycle after acceptance |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | A frame byte is offered |
| tx_data | output | 8 | Frame byte |
| tx_first | output | 1 | Byte is the start of a frame |
| tx_last | output | 1 | Byte is the end of a frame |
| tx_ready | input | 1 | MAC takes the byte this cycle |
| mac_late_col | input | 1 | MAC reports a late collision |
| mac_exc_col | input | 1 | MAC reports excessive collisions |
| tx_done | output | 1 | One-cycle completion pulse |

## Verification
A poll written at one clock edge puts `mem_req` up for word 0 at the next edge. Each read then costs the memory's accept delay plus its response delay. Each byte leaves on the edge where `tx_ready` is high. `tx_done` is due one cycle after the write-back is accepted. Because the bench's memory and sink insert random stalls, it records every accepted request and every accepted byte at falling edges and waits on the completion pulse, not on a fixed offset. For the cases that must stay quiet (R3, R4) it watches a fixed 20 to 30 cycle window, which is far longer than the one-cycle start delay.

// File: rtl/txd_pkg.sv
`timescale 1ns/1ps
package txd_pkg;
    localparam int DATA_W       = 32;
    localparam int BYTE_W       = 8;
    localparam int DESC_WORDS   = 4;
    localparam int OFF_CTRL     = 'h00;
    localparam int OFF_POLL     = 'h18;
    localparam int OFF_BASE     = 'h20;
    localparam int CTRL_DMA_BIT = 0;
    localparam int CTRL_TX_BIT  = 5;
    localparam int OWN_BIT      = 31;
    localparam int EOR_BIT      = 31;
    localparam int FS_BIT       = 28;
    localparam int LS_BIT       = 27;
    localparam int LATE_BIT     = 0;
    localparam int EXC_BIT      = 1;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD0_REQ,
        S_RD0_WAIT,
        S_RD1_REQ,
        S_RD1_WAIT,
        S_RD2_REQ,
        S_RD2_WAIT,
        S_BUF_REQ,
        S_BUF_WAIT,
        S_SEND,
        S_WB_REQ,
        S_DONE
    } seq_state_e;
endpackage

// File: rtl/txd_regs.sv
`timescale 1ns/1ps
module txd_regs
    import txd_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              advance_i,
    input  logic              wrap_i,
    output logic              poll_o,
    output logic              run_ok_o,
    output logic [ADDR_W-1:0] ring_ptr_o
);
    typedef struct packed {
        logic              dma_en;
        logic              tx_en;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] ptr;
    } regs_t;

    regs_t q, d;
    logic  hit_ctrl, hit_poll, hit_base;
    logic  unused_wdata;

    assign hit_ctrl     = wr_en_i && (wr_addr_i == REG_AW'(OFF_CTRL));
    assign hit_poll     = wr_en_i && (wr_addr_i == REG_AW'(OFF_POLL));
    assign hit_base     = wr_en_i && (wr_addr_i == REG_AW'(OFF_BASE));
    assign unused_wdata = ^wr_data_i;

    always_comb begin
        d = q;
        if (hit_ctrl) begin
            d.dma_en = wr_data_i[CTRL_DMA_BIT];
            d.tx_en  = wr_data_i[CTRL_TX_BIT];
        end
        if (advance_i) begin
            d.ptr = wrap_i ? q.base : q.ptr + ADDR_W'(DESC_WORDS);
        end
        if (hit_base) begin
            d.base = wr_data_i[ADDR_W+1:2];
            d.ptr  = wr_data_i[ADDR_W+1:2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign poll_o     = hit_poll;
    assign run_ok_o   = q.dma_en && q.tx_en;
    assign ring_ptr_o = q.ptr;

    AST_BASE_WRITE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_base |=> (ring_ptr_o == q.base)) else $error("base write did not reload pointer"); // R2
endmodule

// File: rtl/txd_lane_sel.sv
`timescale 1ns/1ps
module txd_lane_sel
    import txd_pkg::*;
#(
    parameter int LANES = DATA_W / BYTE_W,
    parameter int LW    = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [LW-1:0]     lane_i,
    output logic [BYTE_W-1:0] byte_o
);
    logic [BYTE_W-1:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word_i[g*BYTE_W +: BYTE_W];
    end

    assign byte_o = lanes[lane_i];
endmodule

// File: rtl/txd_seq.sv
`timescale 1ns/1ps
module txd_seq
    import txd_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int LEN_W  = 11,
    parameter int LANES  = DATA_W / BYTE_W,
    parameter int LW     = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll_i,
    input  logic              run_ok_i,
    input  logic [ADDR_W-1:0] ring_ptr_i,
    output logic              advance_o,
    output logic              wrap_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_ready_i,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [DATA_W-1:0] word_o,
    output logic [LW-1:0]     lane_o,
    output logic              tx_valid_o,
    output logic              tx_first_o,
    output logic              tx_last_o,
    input  logic              tx_ready_i,
    input  logic              late_col_i,
    input  logic              exc_col_i,
    output logic              tx_done_o
);
    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] desc;
        logic [ADDR_W-1:0] bufa;
        logic [LEN_W-1:0]  remain;
        logic [LW-1:0]     lane;
        logic [DATA_W-1:0] word;
        logic              fs;
        logic              ls;
        logic              eor;
        logic              first_pend;
        logic              late;
        logic              exc;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d           = q;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = q.desc;
        mem_wdata_o = '0;
        tx_valid_o  = 1'b0;
        tx_first_o  = 1'b0;
        tx_last_o   = 1'b0;
        advance_o   = 1'b0;
        wrap_o      = 1'b0;
        tx_done_o   = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (poll_i && run_ok_i) begin
                    d.desc = ring_ptr_i;
                    d.st   = S_RD0_REQ;
                end
            end
            S_RD0_REQ: begin
                mem_req_o = 1'b1;
                if (mem_ready_i) d.st = S_RD0_WAIT;
            end
            S_RD0_WAIT: begin
                if (mem_rvalid_i) d.st = mem_rdata_i[OWN_BIT] ? S_RD1_REQ : S_IDLE;
            end
            S_RD1_REQ: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.desc + ADDR_W'(1);
                if (mem_ready_i) d.st = S_RD1_WAIT;
            end
            S_RD1_WAIT: begin
                if (mem_rvalid_i) begin
                    d.remain = mem_rdata_i[LEN_W-1:0];
                    d.fs     = mem_rdata_i[FS_BIT];
                    d.ls     = mem_rdata_i[LS_BIT];
                    d.eor    = mem_rdata_i[EOR_BIT];
                    d.st     = S_RD2_REQ;
                end
            end
            S_RD2_REQ: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.desc + ADDR_W'(2);
                if (mem_ready_i) d.st = S_RD2_WAIT;
            end
            S_RD2_WAIT: begin
                if (mem_rvalid_i) begin
                    d.bufa       = mem_rdata_i[ADDR_W+1:2];
                    d.late       = 1'b0;
                    d.exc        = 1'b0;
                    d.first_pend = q.fs;
                    d.st         = (q.remain == '0) ? S_WB_REQ : S_BUF_REQ;
                end
            end
            S_BUF_REQ: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.bufa;
                if (mem_ready_i) d.st = S_BUF_WAIT;
            end
            S_BUF_WAIT: begin
                if (mem_rvalid_i) begin
                    d.word = mem_rdata_i;
                    d.lane = '0;
                    d.bufa = q.bufa + ADDR_W'(1);
                    d.st   = S_SEND;
                end
            end
            S_SEND: begin
                tx_valid_o = 1'b1;
                tx_first_o = q.first_pend;
                tx_last_o  = q.ls && (q.remain == LEN_W'(1));
                d.late     = q.late | late_col_i;
                d.exc      = q.exc | exc_col_i;
                if (tx_ready_i) begin
                    d.first_pend = 1'b0;
                    d.remain     = q.remain - LEN_W'(1);
                    d.lane       = q.lane + LW'(1);
                    if (q.remain == LEN_W'(1))          d.st = S_WB_REQ;
                    else if (q.lane == LW'(LANES - 1))  d.st = S_BUF_REQ;
                end
            end
            S_WB_REQ: begin
                mem_req_o             = 1'b1;
                mem_we_o              = 1'b1;
                mem_wdata_o[LATE_BIT] = q.late;
                mem_wdata_o[EXC_BIT]  = q.exc;
                if (mem_ready_i) begin
                    advance_o = 1'b1;
                    wrap_o    = q.eor;
                    d.st      = S_DONE;
                end
            end
            S_DONE: begin
                tx_done_o = 1'b1;
                d.st      = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_o = q.word;
    assign lane_o = q.lane;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)))
        else $error("memory request dropped or changed while stalled"); // R8
    AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(word_o) && $stable(lane_o)
                                         && $stable(tx_first_o) && $stable(tx_last_o)))
        else $error("byte changed while stalled"); // R8
    AST_GATED_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE && !run_ok_i) |=> (q.st == S_IDLE))
        else $error("fetch started while disabled"); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE) |-> (!mem_req_o && !tx_valid_o && !tx_done_o))
        else $error("activity while idle"); // R4
    AST_WB_CLEARS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> !mem_wdata_o[OWN_BIT])
        else $error("write-back keeps ownership"); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_o |=> !tx_done_o) else $error("done longer than one cycle"); // R10
    AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done_o) |-> $past(mem_req_o && mem_we_o && mem_ready_i))
        else $error("done without accepted write-back"); // R10
endmodule

// File: rtl/txdesc_engine.sv
`timescale 1ns/1ps
module txdesc_engine
    import txd_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int LEN_W  = 11,
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_wr_addr,
    input  logic [31:0]       reg_wr_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_first,
    output logic              tx_last,
    input  logic              tx_ready,
    input  logic              mac_late_col,
    input  logic              mac_exc_col,
    output logic              tx_done
);
    localparam int LANES = DATA_W / BYTE_W;
    localparam int LW    = $clog2(LANES);

    logic              poll, run_ok, advance, wrap;
    logic [ADDR_W-1:0] ring_ptr;
    logic [DATA_W-1:0] cur_word;
    logic [LW-1:0]     cur_lane;

    txd_regs #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (reg_wr_en),
        .wr_addr_i  (reg_wr_addr),
        .wr_data_i  (reg_wr_data),
        .advance_i  (advance),
        .wrap_i     (wrap),
        .poll_o     (poll),
        .run_ok_o   (run_ok),
        .ring_ptr_o (ring_ptr)
    );

    txd_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LANES(LANES), .LW(LW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .poll_i       (poll),
        .run_ok_i     (run_ok),
        .ring_ptr_i   (ring_ptr),
        .advance_o    (advance),
        .wrap_o       (wrap),
        .mem_req_o    (mem_req),
        .mem_we_o     (mem_we),
        .mem_addr_o   (mem_addr),
        .mem_wdata_o  (mem_wdata),
        .mem_ready_i  (mem_ready),
        .mem_rvalid_i (mem_rvalid),
        .mem_rdata_i  (mem_rdata),
        .word_o       (cur_word),
        .lane_o       (cur_lane),
        .tx_valid_o   (tx_valid),
        .tx_first_o   (tx_first),
        .tx_last_o    (tx_last),
        .tx_ready_i   (tx_ready),
        .late_col_i   (mac_late_col),
        .exc_col_i    (mac_exc_col),
        .tx_done_o    (tx_done)
    );

    txd_lane_sel #(.LANES(LANES), .LW(LW)) u_lane (
        .word_i (cur_word),
        .lane_i (cur_lane),
        .byte_o (tx_data)
    );
endmodule

// File: tb/txdesc_engine_bench.sv
`timescale 1ns/1ps
module txdesc_engine_bench;
    localparam int AW     = 30;
    localparam int BUF_W  = 512;
    localparam int RING_N = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr_en;
    logic [7:0]  reg_wr_addr;
    logic [31:0] reg_wr_data;
    logic        mem_req, mem_we, mem_ready, mem_rvalid;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        tx_valid, tx_first, tx_last, tx_ready, mac_late_col, mac_exc_col, tx_done;
    logic [7:0]  tx_data;

    always #2.5 clk = ~clk;

    txdesc_engine u_txdesc_engine (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_first(tx_first), .tx_last(tx_last),
        .tx_ready(tx_ready), .mac_late_col(mac_late_col), .mac_exc_col(mac_exc_col),
        .tx_done(tx_done)
    );

    logic [31:0]   mem [0:1023];
    logic [AW-1:0] rd_log [0:63];
    logic [AW-1:0] wr_addr_log [0:7];
    logic [31:0]   wr_data_log [0:7];
    logic [7:0]    rx_data [0:255];
    bit            rx_first [0:255];
    bit            rx_last [0:255];
    int rd_cnt, wr_cnt, rx_cnt, done_cnt, req_cnt, hold_viol;
    int vectors = 0, fails = 0;
    bit want_late, want_exc, finished;
    int pend;
    logic [31:0] pend_data;
    logic [AW-1:0] exp_ptr, base_w;
    int ring_idx;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int i);
        logic [31:0] w;
        w = mem[BUF_W + i/4];
        return w[8*(i%4) +: 8];
    endfunction

    // memory model and byte sink, all sampling at falling edges
    initial begin : responder
        bit pr_stall, pt_stall, pf, pl;
        logic [AW-1:0] paddr;
        logic pwe;
        logic [7:0] pdata;
        pr_stall = 0; pt_stall = 0; pf = 0; pl = 0; paddr = '0; pwe = 0; pdata = '0;
        mem_ready = 0; mem_rvalid = 0; mem_rdata = '0; tx_ready = 0;
        mac_late_col = 0; mac_exc_col = 0; pend = 0; pend_data = '0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin mem_rvalid = 1'b1; mem_rdata = pend_data; end
            end
            if (pr_stall && !(mem_req && mem_addr == paddr && mem_we == pwe)) hold_viol++;
            if (pt_stall && !(tx_valid && tx_data == pdata && tx_first == pf && tx_last == pl)) hold_viol++;
            mem_ready    = ($urandom % 4) != 0;
            tx_ready     = ($urandom % 3) != 0;
            mac_late_col = 1'b0;
            mac_exc_col  = 1'b0;
            if (tx_valid && want_late) begin mac_late_col = 1'b1; want_late = 0; end
            if (tx_valid && want_exc)  begin mac_exc_col  = 1'b1; want_exc  = 0; end
            if (mem_req) req_cnt++;
            if (mem_req && mem_ready) begin
                if (mem_we) begin
                    if (wr_cnt < 8) begin wr_addr_log[wr_cnt] = mem_addr; wr_data_log[wr_cnt] = mem_wdata; end
                    wr_cnt++;
                    mem[mem_addr[9:0]] = mem_wdata;
                end else begin
                    if (rd_cnt < 64) rd_log[rd_cnt] = mem_addr;
                    rd_cnt++;
                    pend = 1 + ($urandom % 3);
                    pend_data = mem[mem_addr[9:0]];
                end
            end
            if (tx_valid && tx_ready) begin
                if (rx_cnt < 256) begin
                    rx_data[rx_cnt] = tx_data; rx_first[rx_cnt] = tx_first; rx_last[rx_cnt] = tx_last;
                end
                rx_cnt++;
            end
            if (tx_done) done_cnt++;
            pr_stall = mem_req && !mem_ready; paddr = mem_addr; pwe = mem_we;
            pt_stall = tx_valid && !tx_ready; pdata = tx_data; pf = tx_first; pl = tx_last;
        end
    end

    task automatic reg_write(input logic [7:0] a, input logic [31:0] dat);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = dat;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic clear_logs();
        rd_cnt = 0; wr_cnt = 0; rx_cnt = 0; done_cnt = 0; req_cnt = 0;
    endtask

    task automatic set_base(input logic [31:0] a);
        reg_write(8'h20, a);
        base_w = a[31:2]; exp_ptr = a[31:2]; ring_idx = 0;
    endtask

    task automatic poll_disabled(input logic [31:0] ctrl);
        reg_write(8'h00, ctrl);
        clear_logs();
        reg_write(8'h18, $urandom);
        repeat (20) @(negedge clk);
        check(req_cnt == 0, "R3", "memory requests with enables off", req_cnt, 0);
        reg_write(8'h00, 32'h21);
    endtask

    task automatic run_desc(input bit owned, input int len, input bit fs, input bit ls,
                            input bit lc, input bit ec, input bit poll_busy);
        logic [AW-1:0] dsc;
        logic [31:0] tmp;
        bit eor, inj;
        int t, mism, bad, exp_reads;
        dsc = exp_ptr;
        eor = (ring_idx == RING_N - 1);
        for (int i = 0; i < 20; i++) mem[BUF_W + i] = $urandom;
        tmp = $urandom; tmp[31] = owned;                  mem[dsc[9:0]] = tmp;
        tmp = $urandom; tmp[31] = eor; tmp[28] = fs; tmp[27] = ls; tmp[10:0] = 11'(len);
        mem[dsc[9:0] + 10'd1] = tmp;
        mem[dsc[9:0] + 10'd2] = 32'(BUF_W * 4);
        mem[dsc[9:0] + 10'd3] = $urandom;
        want_late = lc; want_exc = ec;
        clear_logs();
        reg_write(8'h18, $urandom);
        if (owned) begin
            t = 0; inj = 0;
            while (done_cnt == 0 && t < 3000) begin
                @(negedge clk); t++;
                if (poll_busy && !inj && rx_cnt >= 1) begin inj = 1; reg_write(8'h18, $urandom); end
            end
            repeat (5) @(negedge clk);
        end else begin
            repeat (30) @(negedge clk);
        end
        want_late = 0; want_exc = 0;
        check(rd_cnt >= 1, "R2", "poll started a fetch", rd_cnt, 1);
        check(rd_log[0] == dsc, "R11", "word 0 fetched at ring position", 32'(rd_log[0]), 32'(dsc));
        if (!owned) begin
            check(rd_cnt == 1 && wr_cnt == 0 && rx_cnt == 0 && done_cnt == 0, "R4",
                  "activity after unowned descriptor", rd_cnt + wr_cnt + rx_cnt + done_cnt, 1);
            return;
        end
        exp_reads = 3 + (len + 3) / 4;
        check(rd_log[1] == dsc + 1 && rd_log[2] == dsc + 2, "R5", "word 1/2 addresses",
              32'(rd_log[2]), 32'(dsc + 2));
        check(rd_cnt == exp_reads, "R6", "number of reads", rd_cnt, exp_reads);
        if (poll_busy) check(rd_cnt == exp_reads, "R12", "reads with poll while busy", rd_cnt, exp_reads);
        check(rx_cnt == len, "R6", "byte count", rx_cnt, len);
        mism = 0;
        for (int i = 0; i < len && i < rx_cnt; i++) if (rx_data[i] !== exp_byte(i)) mism++;
        check(mism == 0, "R6", "byte mismatches", mism, 0);
        bad = 0;
        for (int i = 0; i < rx_cnt && i < 256; i++) begin
            if (rx_first[i] != (fs && i == 0)) bad++;
            if (rx_last[i] != (ls && i == len - 1)) bad++;
        end
        check(bad == 0, "R7", "marker errors", bad, 0);
        check(wr_cnt == 1 && wr_addr_log[0] == dsc, "R9", "write-back address", 32'(wr_addr_log[0]), 32'(dsc));
        check(wr_data_log[0] == {30'b0, ec && len > 0, lc && len > 0}, "R9", "write-back status",
              wr_data_log[0], {30'b0, ec && len > 0, lc && len > 0});
        check(done_cnt == 1, "R10", "done pulse cycles", done_cnt, 1);
        exp_ptr  = eor ? base_w : dsc + 4;
        ring_idx = eor ? 0 : ring_idx + 1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R10 watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd7321));
        finished = 0; hold_viol = 0; want_late = 0; want_exc = 0;
        reg_wr_en = 0; reg_wr_addr = '0; reg_wr_data = '0;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        clear_logs();
        rst_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!mem_req && !tx_valid && !tx_done, "R1", "outputs after reset",
              {29'b0, mem_req, tx_valid, tx_done}, 0);
        // R1: base resets to zero, so the first fetch goes to word 0 (unowned)
        reg_write(8'h00, 32'h21);
        clear_logs();
        reg_write(8'h18, 32'h0);
        repeat (30) @(negedge clk);
        check(rd_cnt == 1 && rd_log[0] == '0, "R1", "first fetch address after reset", 32'(rd_log[0]), 0);

        poll_disabled(32'h0000_0001);
        poll_disabled(32'h0000_0020);
        poll_disabled(32'hFFFF_FFDE);

        set_base(32'h0000_0100);
        run_desc(1, 1, 1, 1, 0, 0, 0);
        run_desc(1, 4, 1, 1, 1, 0, 0);
        run_desc(1, 5, 0, 1, 0, 1, 0);
        run_desc(1, 0, 1, 1, 1, 1, 0);
        run_desc(0, 8, 1, 1, 0, 0, 0);
        run_desc(1, 20, 1, 0, 0, 0, 1);
        run_desc(1, 64, 1, 1, 1, 1, 0);

        for (int n = 0; n < 40; n++) begin
            if (n == 20) set_base(32'h0000_0303);
            run_desc(($urandom % 8) != 0, $urandom % 65, $urandom % 2, $urandom % 2,
                     ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 5) == 0);
        end
        check(hold_viol == 0, "R8", "stall hold violations", hold_viol, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule